// File: doc/BRIEF.md
# Locked ATA Timing Register Window

This block sits between a host access port and the task-file registers of a two-device ATA channel. It decodes byte and halfword accesses in an eight-byte command-block window. While the window is locked, every access is forwarded to a pass-through port, and read data comes back one cycle later.

A strict three-step access sequence turns the same window into a hidden control bank. The bank holds staged read and write cycle timings for each device, a control register, a read-only strap register and a miscellaneous register. The miscellaneous register selects the target device and carries the address-setup value, which both devices share. The staged values reach the timing outputs, which feed a downstream cycle generator, only when a commit code is written to the control register. A relock code written at offset 2 returns the window to task-file mode.

Top module: `ata_tmg_window`

## Requirements
- R1: After reset the window is locked (`ctl_mode`=0). All four device timing outputs equal `RST_TIMING` (default 0xFF), and `addr_setup` equals `RST_ASETUP` (default 0xF).
- R2: While locked, each access appears on the `tf_*` port in the same cycle with unchanged write, size, offset and data. A read returns `tf_rdata` on `rsp_rdata` with `rsp_valid` high in the following cycle.
- R3: The window enters control mode after exactly these three accesses in order: a halfword read at offset 1, a second halfword read at offset 1, and a byte write of 0x03 at offset 2. `ctl_mode` is high from the cycle after the write.
- R4: Any access that is not the next expected step returns the sequencer to idle. This includes a third halfword read at offset 1, a byte read at offset 1, any intervening access, and a written value other than 0x03. The window then stays locked.
- R5: In control mode `tf_valid` stays low, and reads return control-bank data, zero-extended to 16 bits.
- R6: In control mode, a byte write of 0x83 at offset 2 relocks the window. A read issued in the cycle before the relock still returns bank data.
- R7: The miscellaneous register sits at offset 6. Bit 0 selects the device (0 or 1) whose staged read timing (offset 0) and write timing (offset 1) later writes fill. Bits 7:4 hold the shared address-setup value.
- R8: A write of 0x85 to the control register at offset 3 copies both staged timing sets and the staged address setup to the outputs. No other write changes the timing outputs or `addr_setup`, including any other value written to offset 3.
- R9: Bit 0 of the strap register at offset 5 reads back the `strap_clk25` input (0 means a 33 MHz bus clock, 1 means 25 MHz). The other bits read 0, and writes to offset 5 are ignored.
- R10: Bank reads return the following: at offset 0, the staged read timing of the selected device; at offset 1, its staged write timing; at offset 3, the last control value written; at offset 6, the miscellaneous value. Offsets 2, 4 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_half | input | 1 | 1 = halfword, 0 = byte |
| acc_addr | input | 3 | Window offset |
| acc_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |
| tf_valid | output | 1 | Task-file access strobe |
| tf_write | output | 1 | Task-file write flag |
| tf_half | output | 1 | Task-file size flag |
| tf_addr | output | 3 | Task-file offset |
| tf_wdata | output | 16 | Task-file write data |
| tf_rdata | input | 16 | Task-file read data |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| ctl_mode | output | 1 | Window unlocked into the control bank |
| dev0_rd_tmg | output | 8 | Committed read timing, device 0 |
| dev0_wr_tmg | output | 8 | Committed write timing, device 0 |
| dev1_rd_tmg | output | 8 | Committed read timing, device 1 |
| dev1_wr_tmg | output | 8 | Committed write timing, device 1 |
| addr_setup | output | 4 | Committed shared address setup |

## Verification
Two functions can fall in the same cycle. A bank read's response leaves the block while the next access, a relock write, switches the window back to task-file mode. The bench issues the miscellaneous-register read and the 0x83 write back to back, with the task-file model driving a distinct pattern. The response must carry the bank value, and the read that follows the relock must carry the task-file pattern. Commit is also checked against near-miss control values, and the timing outputs are compared before and after each control write.

// File: rtl/ata_tmg_window.sv
module ata_tmg_window #(
  parameter logic [7:0] RST_TIMING = 8'hFF,
  parameter logic [3:0] RST_ASETUP = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic        acc_half,
  input  logic [2:0]  acc_addr,
  input  logic [15:0] acc_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        tf_valid,
  output logic        tf_write,
  output logic        tf_half,
  output logic [2:0]  tf_addr,
  output logic [15:0] tf_wdata,
  input  logic [15:0] tf_rdata,
  input  logic        strap_clk25,
  output logic        ctl_mode,
  output logic [7:0]  dev0_rd_tmg,
  output logic [7:0]  dev0_wr_tmg,
  output logic [7:0]  dev1_rd_tmg,
  output logic [7:0]  dev1_wr_tmg,
  output logic [3:0]  addr_setup
);
  localparam logic [7:0] UNLOCK_KEY = 8'h03;
  localparam logic [7:0] RELOCK_KEY = 8'h83;
  localparam logic [7:0] COMMIT_KEY = 8'h85;
  localparam logic [2:0] OFS_RDT  = 3'd0;
  localparam logic [2:0] OFS_WRT  = 3'd1;
  localparam logic [2:0] OFS_KEY  = 3'd2;
  localparam logic [2:0] OFS_CTL  = 3'd3;
  localparam logic [2:0] OFS_STRP = 3'd5;
  localparam logic [2:0] OFS_MISC = 3'd6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ONE, SQ_TWO} sq_t;
  sq_t seq_q;

  logic [7:0] st_rd [2];
  logic [7:0] st_wr [2];
  logic [7:0] act_rd [2];
  logic [7:0] act_wr [2];
  logic [7:0] misc_q, ctrl_q, bank_rd;
  logic [3:0] as_q;

  wire [7:0] wb     = acc_wdata[7:0];
  wire       sel    = misc_q[0];
  wire       rd_one = acc_valid & ~acc_write & acc_half & (acc_addr == OFS_WRT);
  wire       key_wr = acc_valid & acc_write & ~acc_half & (acc_addr == OFS_KEY) & (wb == UNLOCK_KEY);
  wire       bw     = ctl_mode & acc_valid & acc_write;
  wire       relock = bw & (acc_addr == OFS_KEY) & (wb == RELOCK_KEY);
  wire       commit = bw & (acc_addr == OFS_CTL) & (wb == COMMIT_KEY);

  assign tf_valid = acc_valid & ~ctl_mode;
  assign tf_write = acc_write;
  assign tf_half  = acc_half;
  assign tf_addr  = acc_addr;
  assign tf_wdata = acc_wdata;

  assign dev0_rd_tmg = act_rd[0];
  assign dev0_wr_tmg = act_wr[0];
  assign dev1_rd_tmg = act_rd[1];
  assign dev1_wr_tmg = act_wr[1];
  assign addr_setup  = as_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q    <= SQ_IDLE;
      ctl_mode <= 1'b0;
    end else if (ctl_mode) begin
      seq_q <= SQ_IDLE;
      if (relock) ctl_mode <= 1'b0;
    end else if (acc_valid) begin
      case (seq_q)
        SQ_IDLE: seq_q <= rd_one ? SQ_ONE : SQ_IDLE;
        SQ_ONE:  seq_q <= rd_one ? SQ_TWO : SQ_IDLE;
        default: begin
          seq_q <= SQ_IDLE;
          if (key_wr) ctl_mode <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        st_rd[i]  <= RST_TIMING;
        st_wr[i]  <= RST_TIMING;
        act_rd[i] <= RST_TIMING;
        act_wr[i] <= RST_TIMING;
      end
      misc_q <= {RST_ASETUP, 4'h0};
      ctrl_q <= 8'h00;
      as_q   <= RST_ASETUP;
    end else if (bw) begin
      case (acc_addr)
        OFS_RDT:  st_rd[sel] <= wb;
        OFS_WRT:  st_wr[sel] <= wb;
        OFS_MISC: misc_q     <= wb;
        OFS_CTL: begin
          ctrl_q <= wb;
          if (commit) begin
            for (int i = 0; i < 2; i++) begin
              act_rd[i] <= st_rd[i];
              act_wr[i] <= st_wr[i];
            end
            as_q <= misc_q[7:4];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (acc_addr)
      OFS_RDT:  bank_rd = st_rd[sel];
      OFS_WRT:  bank_rd = st_wr[sel];
      OFS_CTL:  bank_rd = ctrl_q;
      OFS_STRP: bank_rd = {7'd0, strap_clk25};
      OFS_MISC: bank_rd = misc_q;
      default:  bank_rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 16'h0000;
    end else begin
      rsp_valid <= acc_valid & ~acc_write;
      if (acc_valid & ~acc_write)
        rsp_rdata <= ctl_mode ? {8'h00, bank_rd} : tf_rdata;
    end
  end

  // R3
  unlock_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_mode) |-> $past(acc_valid && acc_write && !acc_half &&
                              acc_addr == OFS_KEY && acc_wdata[7:0] == UNLOCK_KEY));
  // R6
  relock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_mode) |-> $past(acc_valid && acc_write && acc_addr == OFS_KEY &&
                              acc_wdata[7:0] == RELOCK_KEY));
  // R2
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rsp_valid);
  // R8
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_mode && acc_valid && acc_write && acc_addr == OFS_CTL && acc_wdata[7:0] == COMMIT_KEY)
    |=> ($stable(dev0_rd_tmg) && $stable(dev1_wr_tmg) && $stable(addr_setup)));
  // R5
  tf_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode && acc_valid && !acc_write) |=> rsp_rdata[15:8] == 8'h00);
endmodule

// File: tb/ata_tmg_window_tb.sv
module ata_tmg_window_tb_top;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_half = 0;
  logic [2:0] acc_addr = 0;
  logic [15:0] acc_wdata = 0;
  logic rsp_valid, tf_valid, tf_write, tf_half, ctl_mode;
  logic [15:0] rsp_rdata, tf_wdata, tf_rdata;
  logic [2:0] tf_addr;
  logic strap_clk25 = 1;
  logic [7:0] d0r, d0w, d1r, d1w;
  logic [3:0] asu;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic s_tv, s_tw, s_th;
  logic [2:0] s_ta;
  logic [15:0] s_td;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] tf_model(logic [2:0] a);
    return {13'h1A2C, a};
  endfunction
  assign tf_rdata = tf_model(tf_addr);

  ata_tmg_window dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_half(acc_half), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tf_valid(tf_valid),
    .tf_write(tf_write), .tf_half(tf_half), .tf_addr(tf_addr), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .strap_clk25(strap_clk25), .ctl_mode(ctl_mode),
    .dev0_rd_tmg(d0r), .dev0_wr_tmg(d0w), .dev1_rd_tmg(d1r), .dev1_wr_tmg(d1w),
    .addr_setup(asu));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic h, input logic [2:0] a, input logic [15:0] d);
    acc_valid = 1; acc_write = w; acc_half = h; acc_addr = a; acc_wdata = d;
    #1;
    s_tv = tf_valid; s_tw = tf_write; s_th = tf_half; s_ta = tf_addr; s_td = tf_wdata;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic rd(input logic h, input logic [2:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(0, h, a, 16'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    acc(1, 0, a, {8'h00, d});
  endtask

  task automatic tmg(input logic [7:0] a, b, c, e, input logic [3:0] s, input string tag);
    chk(d0r == a, {tag, " dev0 rd"}, d0r, a);
    chk(d0w == b, {tag, " dev0 wr"}, d0w, b);
    chk(d1r == c, {tag, " dev1 rd"}, d1r, c);
    chk(d1w == e, {tag, " dev1 wr"}, d1w, e);
    chk(asu == s, {tag, " asetup"}, asu, s);
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctl_mode == 0, "R1 locked after reset", ctl_mode, 0);
    tmg(8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'hF, "R1 reset");

    rd(1, 3'd4, tf_model(3'd4), "R2 locked read data");
    chk(s_tv && !s_tw && s_th && s_ta == 4, "R2 read forwarded", {s_tv, s_tw, s_th, s_ta}, 6'b101100);
    wr(3'd7, 8'h5A);
    chk(s_tv && s_tw && !s_th && s_ta == 7 && s_td == 16'h005A, "R2 write forwarded", s_td, 16'h005A);

    rd(1, 1, tf_model(1), "R4 tf"); wr(3'd4, 8'h00);
    rd(1, 1, tf_model(1), "R4 tf"); wr(3'd2, 8'h03);
    chk(ctl_mode == 0, "R4 intervening access", ctl_mode, 0);
    rd(1, 1, tf_model(1), "R4 tf"); rd(1, 1, tf_model(1), "R4 tf");
    rd(1, 1, tf_model(1), "R4 tf"); wr(3'd2, 8'h03);
    chk(ctl_mode == 0, "R4 third read", ctl_mode, 0);
    rd(0, 1, tf_model(1), "R4 tf"); rd(0, 1, tf_model(1), "R4 tf"); wr(3'd2, 8'h03);
    chk(ctl_mode == 0, "R4 byte reads", ctl_mode, 0);
    rd(1, 1, tf_model(1), "R4 tf"); rd(1, 1, tf_model(1), "R4 tf"); wr(3'd2, 8'h04);
    chk(ctl_mode == 0, "R4 wrong key", ctl_mode, 0);

    rd(1, 1, tf_model(1), "R3 tf"); rd(1, 1, tf_model(1), "R3 tf"); wr(3'd2, 8'h03);
    chk(s_tv == 1, "R3 key write forwarded", s_tv, 1);
    chk(ctl_mode == 1, "R3 unlocked", ctl_mode, 1);

    rd(1, 3'd0, 16'h00FF, "R5 bank read staged reset");
    chk(s_tv == 0, "R5 tf hidden", s_tv, 0);
    rd(0, 3'd5, 16'h0001, "R9 strap 25MHz");
    wr(3'd5, 8'hFE);
    strap_clk25 = 0;
    rd(0, 3'd5, 16'h0000, "R9 strap 33MHz after write");

    wr(3'd6, 8'h50); wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    wr(3'd6, 8'h71); wr(3'd0, 8'h56); wr(3'd1, 8'h78);
    rd(0, 3'd0, 16'h0056, "R7 dev1 staged rd");
    wr(3'd6, 8'h70);
    rd(0, 3'd1, 16'h0034, "R7 dev0 staged wr");
    wr(3'd6, 8'h71);
    tmg(8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'hF, "R8 before commit");
    wr(3'd3, 8'h84);
    tmg(8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'hF, "R8 near-miss control");
    rd(0, 3'd3, 16'h0084, "R10 control readback");
    wr(3'd3, 8'h85);
    tmg(8'h12, 8'h34, 8'h56, 8'h78, 4'h7, "R8 commit");
    rd(0, 3'd4, 16'h0000, "R10 unused offset");

    rd(0, 3'd6, 16'h0071, "R6 bank read before relock");
    wr(3'd2, 8'h83);
    chk(ctl_mode == 0, "R6 relocked", ctl_mode, 0);
    rd(1, 3'd1, tf_model(1), "R6 tf read after relock");
    tmg(8'h12, 8'h34, 8'h56, 8'h78, 4'h7, "R8 kept after relock");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule